// File: doc/BRIEF.md
# Multi-Select SPI Master Engine

This block is a master-only serial peripheral interface engine. A host programs it through a byte-wide register port: one write strobe with address and data, plus a read address that returns a byte without side effects. A transfer is 1 to 32 bits long. It goes out MSB-first or LSB-first. SCK is derived from the system clock by a power-of-two divider, with an extra divide-by-four option. Clock polarity and clock phase can each be selected.

Both directions are double buffered. The TX holding register can be refilled while the current word shifts out. If a new word is pending when the current word ends, the engine goes straight on with it and keeps chip select low. This lets packets longer than 32 bits be built from several words. Each completed RX word is moved into a holding register, and a ready flag is raised.

Four active-low select lines are decoded from a field. Line 3 can also carry a one-cycle framing strobe just before the first SCK edge of each word, or a one-cycle load strobe just after select is released. A status byte reports:
- bus idle, which is the AND of all four select lines;
- a sticky underrun flag for chained packets that ran dry;
- RX ready;
- TX pending;
- busy.

Top module: `spi_mstr_engine`

## Requirements
- R1: After reset, all four select lines are high and SCK is low. The status byte at address 2 reads 8'h01: bit0 bus idle, bit1 underrun, bit2 RX ready, bit3 TX pending, bit4 busy.
- R2: The SCK period is 2^(k+1) system clocks, where k is bits [2:0] of the control register at address 0. When the slow bit (bit3) is set, the period is four times longer.
- R3: The select field (control bits [5:4]) picks line n of cs_n_o. Only that line goes low during a transfer, and it goes high again afterwards.
- R4: Control bit7 is polarity and sets the SCK level between transfers. Control bit6 is phase. With phase 0, output changes on the rising SCK edge and input is sampled on the falling edge. With phase 1, output changes on the falling edge and input is sampled on the rising edge.
- R5: The length field (bits [4:0] of the frame register at address 1) holds length-1, for lengths 1 to 32. Frame bit5 selects LSB-first; when it is 0 the order is MSB-first.
- R6: TX bytes are written at addresses 4..7, least significant byte first. Writing address 4 marks the word pending and starts a transfer.
- R7: At the end of a transfer, the received word appears right-aligned at addresses 4..7, and status bit2 is set. Writing 1 to bit1 of address 2 clears status bit2.
- R8: When frame bit6 is set, cs_n_o[3] goes low for exactly one system clock, in the cycle just before the first SCK edge of each word.
- R9: When frame bit7 is set and frame bit6 is clear, cs_n_o[3] goes low for exactly one system clock, in the first cycle after the select line rises. When both bits are set, only the framing strobe appears.
- R10: Status bit0 equals the AND of all four select lines. It reads 0 within four system clocks of the write that starts a transfer.
- R11: If a word is written at address 4 while a transfer runs, it follows the current word with no break in the select line.
- R12: If chaining is enabled (bit0 of address 3) and a word ends with no word pending, status bit1 is set. It stays set until 1 is written to bit0 of address 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 8 | Register read data |
| sck_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |
| cs_n_o | output | 4 | Active-low select lines; line 3 also carries the strobes |

## Verification
The hardest case to reach is a seamless chained packet. The second word has to land in the TX holding register after the first word has been taken into the shift register, but before that first word's last bit. If it lands outside that window, the run becomes either a lost word or two separate transfers. The bench uses a divider slow enough that four byte writes fit well inside one word. It then checks for a single select release, the full 16-bit stream on sdo, and the underrun flag raised by the dry word end that follows. A serial slave model in the bench follows the phase rules, so every polarity and phase pair is checked bit by bit on both data lines.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int HW = 8;
  localparam int AW = 3;

  localparam logic [AW-1:0] A_CTRL  = 3'd0;
  localparam logic [AW-1:0] A_FRAME = 3'd1;
  localparam logic [AW-1:0] A_STAT  = 3'd2;
  localparam logic [AW-1:0] A_MODE  = 3'd3;
  localparam logic [AW-1:0] A_D0    = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_ACT, ST_INACT, ST_TAIL, ST_LDP
  } eng_st_e;

  typedef struct packed {
    logic       cpol;
    logic       cpha;
    logic [1:0] csel;
    logic       slow;
    logic [2:0] spd;
  } ctrl_t;

  typedef struct packed {
    logic       ld_en;
    logic       fs_en;
    logic       lsb;
    logic [4:0] lenm1;
  } frame_t;
endpackage

// File: rtl/spi_eng_regs.sv
module spi_eng_regs
  import spi_eng_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [HW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [HW-1:0] rd_data_o,
  output ctrl_t         ctrl_o,
  output frame_t        frame_o,
  output logic          chain_o,
  output logic [DW-1:0] tx_word_o,
  output logic          tx_pend_o,
  input  logic          take_i,
  input  logic [DW-1:0] rx_word_i,
  input  logic          rx_load_i,
  input  logic          ur_set_i,
  input  logic          bus_idle_i,
  input  logic          busy_i
);
  localparam int NB = DW / HW;
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;

  ctrl_t         ctrl_q;
  frame_t        frame_q;
  logic          chain_q, pend_q, ur_q, rdy_q;
  logic [DW-1:0] tx_hold_q, rx_hold_q;
  logic          wr_stat, wr_d0;
  logic [IW-1:0] rd_idx;

  assign wr_stat = wr_en_i && (wr_addr_i == A_STAT);
  assign wr_d0   = wr_en_i && (wr_addr_i == A_D0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      frame_q <= '{ld_en: 1'b0, fs_en: 1'b0, lsb: 1'b0, lenm1: 5'd7};
      chain_q <= 1'b0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_CTRL)  ctrl_q  <= ctrl_t'(wr_data_i);
      if (wr_addr_i == A_FRAME) frame_q <= frame_t'(wr_data_i);
      if (wr_addr_i == A_MODE)  chain_q <= wr_data_i[0];
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tx_hold_q[HW*b +: HW] <= '0;
      else if (wr_en_i && wr_addr_i == AW'(int'(A_D0) + b)) tx_hold_q[HW*b +: HW] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b0;
      ur_q      <= 1'b0;
      rdy_q     <= 1'b0;
      rx_hold_q <= '0;
    end else begin
      pend_q <= (pend_q && !take_i) || wr_d0;
      if (ur_set_i) ur_q <= 1'b1;
      else if (wr_stat && wr_data_i[0]) ur_q <= 1'b0;
      if (rx_load_i) begin
        rx_hold_q <= rx_word_i;
        rdy_q     <= 1'b1;
      end else if (wr_stat && wr_data_i[1]) begin
        rdy_q <= 1'b0;
      end
    end
  end

  assign rd_idx = IW'(rd_addr_i - A_D0);

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i >= A_D0) begin
      rd_data_o = rx_hold_q[HW*rd_idx +: HW];
    end else begin
      unique case (rd_addr_i)
        A_CTRL:  rd_data_o = ctrl_q;
        A_FRAME: rd_data_o = frame_q;
        A_STAT:  rd_data_o = {3'b000, busy_i, pend_q, rdy_q, ur_q, bus_idle_i};
        default: rd_data_o = {7'd0, chain_q};
      endcase
    end
  end

  assign ctrl_o    = ctrl_q;
  assign frame_o   = frame_q;
  assign chain_o   = chain_q;
  assign tx_word_o = tx_hold_q;
  assign tx_pend_o = pend_q;

  // R12
  ur_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ur_q && !(wr_stat && wr_data_i[0])) |=> ur_q);
endmodule

// File: rtl/spi_eng_div.sv
module spi_eng_div #(
  parameter int SPD_W   = 3,
  parameter int SLOW_SH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SPD_W-1:0] spd_i,
  input  logic             slow_i,
  input  logic             restart_i,
  output logic             half_end_o
);
  localparam int DIV_W = (1 << SPD_W) - 1 + SLOW_SH + 1;

  logic [DIV_W-1:0] cnt_q, base, hm1;

  assign base = DIV_W'(1) << spd_i;
  assign hm1  = (slow_i ? (base << SLOW_SH) : base) - 1'b1;
  assign half_end_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (restart_i || half_end_o) cnt_q <= hm1;
    else                              cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/spi_eng_shift.sv
module spi_eng_shift #(
  parameter int DW = 32,
  parameter int LW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lsb_i,
  input  logic [LW-1:0] lenm1_i,
  input  logic          load_i,
  input  logic [DW-1:0] word_i,
  input  logic          pop_i,
  input  logic          sample_i,
  input  logic          sdi_i,
  output logic          sdo_o,
  output logic [DW-1:0] rx_word_o
);
  logic [LW:0]   pad;
  logic [DW-1:0] aligned, src, tx_q, rx_q, mask;
  logic          sdo_q;

  assign pad     = (LW+1)'(DW) - ({1'b0, lenm1_i} + 1'b1);
  assign aligned = lsb_i ? word_i : (word_i << pad);
  assign src     = load_i ? aligned : tx_q;
  assign mask    = {DW{1'b1}} >> pad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      rx_q  <= '0;
      sdo_q <= 1'b0;
    end else begin
      if (load_i || pop_i) tx_q <= pop_i ? (lsb_i ? (src >> 1) : (src << 1)) : src;
      if (pop_i) sdo_q <= lsb_i ? src[0] : src[DW-1];
      if (sample_i) rx_q <= lsb_i ? {sdi_i, rx_q[DW-1:1]} : {rx_q[DW-2:0], sdi_i};
    end
  end

  assign sdo_o     = sdo_q;
  assign rx_word_o = lsb_i ? (rx_q >> pad) : (rx_q & mask);
endmodule

// File: rtl/spi_eng_csgen.sv
module spi_eng_csgen #(
  parameter int NCS = 4,
  parameter int SW  = $clog2(NCS)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [SW-1:0]  csel_i,
  input  logic           cs_act_i,
  input  logic           fs_pulse_i,
  input  logic           ld_pulse_i,
  output logic [NCS-1:0] cs_n_o
);
  for (genvar i = 0; i < NCS; i++) begin : g_cs
    if (i == NCS - 1) begin : g_alt
      assign cs_n_o[i] = !((cs_act_i && csel_i == SW'(i)) || fs_pulse_i || ld_pulse_i);
    end else begin : g_std
      assign cs_n_o[i] = !(cs_act_i && csel_i == SW'(i));
    end
  end

  // R3
  cs_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~cs_n_o[NCS-2:0]) <= 1);
  // R8
  fs_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_pulse_i |=> !fs_pulse_i);
endmodule

// File: rtl/spi_mstr_engine.sv
module spi_mstr_engine
  import spi_eng_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [HW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [HW-1:0] rd_data_o,
  output logic          sck_o,
  output logic          sdo_o,
  input  logic          sdi_i,
  output logic [3:0]    cs_n_o
);
  localparam int DW      = 32;
  localparam int LW      = $clog2(DW);
  localparam int SPD_W   = 3;
  localparam int SLOW_SH = 2;
  localparam int NCS     = 4;

  ctrl_t         ctrl;
  frame_t        frame;
  logic          chain, pend, half;
  logic [DW-1:0] tx_word, rx_word;
  eng_st_e       st_q, st_d;
  logic [LW-1:0] bc_q;
  logic          load, pop, sample, word_end, word_end_q, ur_set;
  logic          case_a, last, cs_act, fs_pulse, ld_pulse, busy;

  spi_eng_regs #(.DW(DW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o,
    .ctrl_o(ctrl), .frame_o(frame), .chain_o(chain), .tx_word_o(tx_word),
    .tx_pend_o(pend), .take_i(load), .rx_word_i(rx_word), .rx_load_i(word_end_q),
    .ur_set_i(ur_set), .bus_idle_i(&cs_n_o), .busy_i(busy)
  );

  spi_eng_div #(.SPD_W(SPD_W), .SLOW_SH(SLOW_SH)) u_div (
    .clk_i, .rst_ni, .spd_i(ctrl.spd), .slow_i(ctrl.slow),
    .restart_i(st_q == ST_IDLE), .half_end_o(half)
  );

  spi_eng_shift #(.DW(DW), .LW(LW)) u_shift (
    .clk_i, .rst_ni, .lsb_i(frame.lsb), .lenm1_i(frame.lenm1), .load_i(load),
    .word_i(tx_word), .pop_i(pop), .sample_i(sample), .sdi_i, .sdo_o,
    .rx_word_o(rx_word)
  );

  spi_eng_csgen #(.NCS(NCS)) u_cs (
    .clk_i, .rst_ni, .csel_i(ctrl.csel), .cs_act_i(cs_act),
    .fs_pulse_i(fs_pulse), .ld_pulse_i(ld_pulse), .cs_n_o
  );

  // first edge samples when it is the sampling edge for this polarity
  assign case_a = ctrl.cpol ^ ctrl.cpha;
  assign last   = (bc_q == frame.lenm1);

  always_comb begin
    st_d = st_q; load = 1'b0; pop = 1'b0; sample = 1'b0;
    word_end = 1'b0; ur_set = 1'b0;
    unique case (st_q)
      ST_IDLE: if (pend) begin
        st_d = ST_SETUP; load = 1'b1; pop = case_a;
      end
      ST_SETUP, ST_INACT: if (half) begin
        st_d = ST_ACT;
        if (case_a) sample = 1'b1; else pop = 1'b1;
      end
      ST_ACT: if (half) begin
        if (case_a) pop = !last; else sample = 1'b1;
        if (last) begin
          word_end = 1'b1;
          if (pend) begin
            st_d = ST_SETUP; load = 1'b1; pop = case_a;
          end else begin
            st_d = ST_TAIL; ur_set = chain;
          end
        end else begin
          st_d = ST_INACT;
        end
      end
      ST_TAIL: if (half) st_d = ST_LDP;
      ST_LDP:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      bc_q       <= '0;
      word_end_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      word_end_q <= word_end;
      if (st_q == ST_IDLE || word_end) bc_q <= '0;
      else if (st_q == ST_ACT && half) bc_q <= bc_q + 1'b1;
    end
  end

  assign cs_act   = (st_q == ST_SETUP) || (st_q == ST_ACT) || (st_q == ST_INACT) || (st_q == ST_TAIL);
  assign fs_pulse = (st_q == ST_SETUP) && half && frame.fs_en;
  assign ld_pulse = (st_q == ST_LDP) && frame.ld_en && !frame.fs_en;
  assign busy     = (st_q != ST_IDLE) || pend;
  assign sck_o    = ctrl.cpol ^ (st_q == ST_ACT);

  // R9
  ld_after_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_pulse |-> ($past(st_q) == ST_TAIL));
  // R11
  chain_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_end && pend) |=> cs_act);
  // R7
  rx_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_end_q |-> $past(st_q) == ST_ACT);
endmodule

// File: tb/spi_mstr_engine_tb.sv
module spi_mstr_engine_tb;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       sck, sdo, sdi;
  logic [3:0] cs_n;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // slave model / monitor state
  int   cyc = 0;
  int   mon_sel = 0;
  bit   mon_cpol = 0, mon_cpha = 0, mon_alt = 0;
  logic [63:0] sl_bits = '0;
  logic        mosi [64];
  int   nmosi = 0, drv = 0, cs_rises = 0, cs3_cnt = 0;
  int   edge_cyc = 0, pulse_cyc = 0, cs_rise_cyc = 0, last_rise = 0, prev_rise = 0;
  bit   first_edge = 0, bad_cs = 0, sck_prev = 0, cs_prev = 0, cs_now;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_mstr_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .sck_o(sck), .sdo_o(sdo), .sdi_i(sdi), .cs_n_o(cs_n)
  );

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      sdi = 1'b0; sck_prev = 1'b0; cs_prev = 1'b0;
    end else begin
      cs_now = !cs_n[mon_sel];
      if (cs_now && !cs_prev) begin
        first_edge = 1;
        if (mon_cpol ^ mon_cpha) begin sdi = sl_bits[0]; drv = 1; end
        else drv = 0;
      end
      if (!cs_now && cs_prev) begin cs_rises++; cs_rise_cyc = cyc; end
      if (sck != sck_prev && cs_now) begin
        if (first_edge) begin edge_cyc = cyc; first_edge = 0; end
        if (sck) begin prev_rise = last_rise; last_rise = cyc; end
        if (sck == mon_cpha) begin
          if (nmosi < 64) mosi[nmosi] = sdo;
          nmosi++;
        end else begin
          if (drv < 64) sdi = sl_bits[drv];
          drv++;
        end
      end
      if (!cs_n[3]) begin cs3_cnt++; pulse_cyc = cyc; end
      for (int i = 0; i < 4; i++)
        if (i != mon_sel && !cs_n[i] && !(i == 3 && mon_alt)) bad_cs = 1;
      sck_prev = sck; cs_prev = cs_now;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic wr_word(input logic [31:0] w);
    for (int b = 1; b < 4; b++) wr(3'(4 + b), w[8*b +: 8]);
    wr(3'd4, w[7:0]);
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(3'd2, s);
      if (!s[4]) break;
      @(negedge clk);
    end
  endtask

  task automatic run_xfer(input bit cpol, input bit cpha, input int k, input bit slow,
                          input int sel, input int len, input bit lsb, input bit fs,
                          input bit ld, input bit chain, input int nw,
                          input logic [31:0] w0, input logic [31:0] w1, input string tag);
    logic [31:0] exp_rx, act_rx, w;
    logic [7:0]  b;
    bit ok;
    wr(3'd0, {cpol, cpha, 2'(sel), slow, 3'(k)});
    wr(3'd1, {ld, fs, lsb, 5'(len - 1)});
    wr(3'd3, {7'd0, chain});
    wr(3'd2, 8'h03);
    mon_sel = sel; mon_cpol = cpol; mon_cpha = cpha; mon_alt = fs | ld;
    sl_bits = 64'h9E37_79B9_7F4A_7C15 ^ {w1, w0};
    nmosi = 0; cs_rises = 0; cs3_cnt = 0; bad_cs = 0;
    wr_word(w0);
    if (nw > 1) wr_word(w1);
    wait_idle();
    repeat (2) @(negedge clk);
    chk(nmosi == nw * len, {tag, " R4 R5 edge count"}, nmosi, nw * len);
    ok = 1;
    for (int i = 0; i < nw; i++) begin
      w = (i == 0) ? w0 : w1;
      for (int j = 0; j < len; j++)
        if (mosi[i*len + j] !== w[lsb ? j : len - 1 - j]) ok = 0;
    end
    chk(ok, {tag, " R5 R6 sdo bit stream"}, 0, 0);
    exp_rx = '0;
    for (int j = 0; j < len; j++) exp_rx[lsb ? j : len - 1 - j] = sl_bits[(nw-1)*len + j];
    for (int i = 0; i < 4; i++) begin rd(3'(4 + i), b); act_rx[8*i +: 8] = b; end
    chk(act_rx == exp_rx, {tag, " R7 rx word"}, act_rx, exp_rx);
    chk(!bad_cs && cs_rises == 1, {tag, " R3 R11 select line use"}, cs_rises, 1);
    chk(sck == cpol, {tag, " R4 sck idle level"}, sck, cpol);
  endtask

  task automatic t_reset();
    logic [7:0] s;
    rd(3'd2, s);
    chk(cs_n == 4'hF, "R1 cs after reset", cs_n, 4'hF);
    chk(sck == 1'b0, "R1 sck after reset", sck, 0);
    chk(s == 8'h01, "R1 status after reset", s, 8'h01);
  endtask

  task automatic t_modes();
    logic [7:0] s;
    run_xfer(0, 0, 0, 0, 0, 8,  0, 0, 0, 0, 1, 32'h0000_00A5, 0, "m00");
    run_xfer(0, 1, 1, 0, 1, 12, 1, 0, 0, 0, 1, 32'h0000_05C3, 0, "m01");
    run_xfer(1, 0, 0, 1, 2, 1,  0, 0, 0, 0, 1, 32'h0000_0001, 0, "m10");
    run_xfer(1, 1, 2, 0, 3, 32, 1, 0, 0, 0, 1, 32'hDEAD_BEEF, 0, "m11");
    run_xfer(0, 0, 0, 0, 1, 32, 0, 0, 0, 0, 1, 32'h1234_5678, 0, "m00w");
    rd(3'd2, s);
    chk(s[1] == 1'b0, "R12 no underrun without chaining", s[1], 0);
    chk(s[2] == 1'b1, "R7 rx ready set", s[2], 1);
    wr(3'd2, 8'h02);
    rd(3'd2, s);
    chk(s[2] == 1'b0, "R7 rx ready cleared", s[2], 0);
  endtask

  task automatic t_div();
    run_xfer(0, 0, 3, 0, 0, 4, 0, 0, 0, 0, 1, 32'h9, 0, "d3");
    chk(last_rise - prev_rise == 16, "R2 period k=3", last_rise - prev_rise, 16);
    run_xfer(0, 0, 1, 1, 0, 4, 0, 0, 0, 0, 1, 32'h6, 0, "d1s");
    chk(last_rise - prev_rise == 16, "R2 period k=1 slow", last_rise - prev_rise, 16);
    run_xfer(1, 1, 0, 1, 0, 4, 0, 0, 0, 0, 1, 32'h3, 0, "d0s");
    chk(last_rise - prev_rise == 8, "R2 period k=0 slow", last_rise - prev_rise, 8);
    run_xfer(0, 0, 0, 0, 0, 4, 0, 0, 0, 0, 1, 32'hA, 0, "d0");
    chk(last_rise - prev_rise == 2, "R2 period k=0", last_rise - prev_rise, 2);
  endtask

  task automatic t_strobes();
    run_xfer(0, 0, 1, 0, 0, 8, 0, 1, 0, 0, 1, 32'h3C, 0, "fs");
    chk(cs3_cnt == 1, "R8 frame strobe width", cs3_cnt, 1);
    chk(pulse_cyc == edge_cyc - 1, "R8 frame strobe position", pulse_cyc, edge_cyc - 1);
    run_xfer(1, 0, 1, 0, 0, 8, 1, 0, 1, 0, 1, 32'h81, 0, "ld");
    chk(cs3_cnt == 1, "R9 load strobe width", cs3_cnt, 1);
    chk(pulse_cyc == cs_rise_cyc, "R9 load strobe position", pulse_cyc, cs_rise_cyc);
    run_xfer(0, 1, 1, 0, 0, 8, 0, 1, 1, 0, 1, 32'h55, 0, "fsld");
    chk(cs3_cnt == 1, "R9 priority single strobe", cs3_cnt, 1);
    chk(pulse_cyc == edge_cyc - 1, "R9 priority frame position", pulse_cyc, edge_cyc - 1);
  endtask

  task automatic t_chain();
    logic [7:0] s;
    run_xfer(0, 0, 1, 0, 2, 8, 0, 0, 0, 1, 2, 32'hC6, 32'h39, "chain");
    rd(3'd2, s);
    chk(s[1] == 1'b1, "R12 underrun set after dry end", s[1], 1);
    wr(3'd2, 8'h00);
    rd(3'd2, s);
    chk(s[1] == 1'b1, "R12 underrun stays without clear", s[1], 1);
    wr(3'd2, 8'h01);
    rd(3'd2, s);
    chk(s[1] == 1'b0, "R12 underrun cleared", s[1], 0);
  endtask

  task automatic t_idle_flag();
    logic [7:0] s;
    wr(3'd0, 8'h03);
    wr(3'd1, 8'h07);
    wr(3'd3, 8'h00);
    mon_sel = 0; mon_alt = 0;
    rd(3'd2, s);
    chk(s[0] == 1'b1, "R10 idle before start", s[0], 1);
    wr_word(32'h77);
    repeat (3) @(negedge clk);
    rd(3'd2, s);
    chk(s[0] == 1'b0, "R10 idle low within 4 clocks", s[0], 0);
    wait_idle();
    rd(3'd2, s);
    chk(s[0] == 1'b1, "R10 idle after end", s[0], 1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_div();
    t_strobes();
    t_chain();
    t_idle_flag();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    summary();
  end
endmodule